// File: doc/BRIEF.md
# Four-Channel Double-Ranked Converter Register Interface

This block is the digital front end of a four-channel, 12-bit voltage converter. A host on a parallel bus writes a code into one of four first-rank (staging) registers, or reads a staging register back, using a 12-bit data path, a two-bit channel address, a read/write line and an active-low chip select. The data path is bidirectional at the chip pin; here it is split into an input word, an output word and an output-enable that the pad ring uses to turn the pin driver on.

A separate active-low load line moves all four staging registers into the second-rank (converter) registers together. While load is low the second rank follows the first on every clock, so all channels change on the same edge. While load is high the second rank holds. The four converter-rank words are the outputs that feed the converters. An asynchronous active-low reset forces both ranks to a build-time code, either mid-scale or zero-scale. The bus is treated as synchronous to the system clock.

Bus cycles are decoded into three named operations: `OP_IDLE` (chip select high), `OP_WRITE` (select low, read/write low) and `OP_READ` (select low, read/write high). The decode is combinational and moves from any operation to any other on each cycle, as the pins dictate; there are no other states.

Top module: `quad_dac_front`

## Requirements
- R1: The address picks the channel as addr=0 for A, 1 for B, 2 for C, 3 for D; channel k occupies bits [12k+11:12k] of `dac_codes`.
- R2: On a rising clock edge with `cs_n` low and `rw` low, `wdata` is stored in the addressed staging register and the other three staging registers keep their values.
- R3: With `cs_n` high, no staging register changes and `rd_oe` is low.
- R4: `rd_oe` is high exactly when `cs_n` is low and `rw` is high, and then `rdata` equals the addressed staging register (not the converter register), in the same cycle.
- R5: On each rising edge with `load_n` low, every converter register takes its staging register's value from before that edge; with `load_n` high, every converter register holds.
- R6: A write made in the same cycle as a low `load_n` reaches the converter register at the following edge, one cycle after the staging register takes it, provided `load_n` is still low there.
- R7: After staging four codes with `load_n` high, one cycle of `load_n` low changes all four converter outputs on the same edge.
- R8: While `rst_n` is low, without waiting for a clock, both ranks of every channel hold the reset code: 800h when `RESET_MID`=1, 000h when `RESET_MID`=0.
- R9: A read cycle leaves every staging and converter register unchanged apart from what `load_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Channel address |
| wdata | input | 12 | Write data from the bus |
| rdata | output | 12 | Readback data to the bus |
| rd_oe | output | 1 | Drive enable for the bus data pins |
| load_n | input | 1 | Converter-rank load, active low, level sensitive |
| dac_codes | output | 48 | Four converter-rank codes, channel A in the low bits |

## Verification
A staging register holding a wrong value shows up on `rdata` in the very next read of that channel, and on its converter output one edge after `load_n` is next low. A converter register that updates while load is high, or misses an update, is visible on `dac_codes` in the cycle after that edge, so every bench cycle compares all four outputs with a model. A swapped address decode appears as the wrong channel changing on the edge after a write, or as a readback returning another channel's word in the same cycle.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;
endpackage

// File: rtl/quad_dac_bus_decode.sv
module quad_dac_bus_decode
    import quad_dac_pkg::*;
#(
    parameter int CH = 4,
    localparam int AW = $clog2(CH)
) (
    input  logic          cs_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    output bus_op_e       op,
    output logic [CH-1:0] wr_en,
    output logic          rd_oe
);
    always_comb begin
        unique case ({cs_n, rw})
            2'b00:   op = OP_WRITE;
            2'b01:   op = OP_READ;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        wr_en = '0;
        rd_oe = 1'b0;
        unique case (op)
            OP_WRITE: wr_en = CH'(1) << addr;
            OP_READ:  rd_oe = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/quad_dac_stage_rank.sv
module quad_dac_stage_rank #(
    parameter int W         = 12,
    parameter int CH        = 4,
    parameter bit RESET_MID = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH-1:0]   wr_en,
    input  logic [W-1:0]    wdata,
    output logic [CH*W-1:0] codes
);
    localparam logic [W-1:0] RST_CODE = RESET_MID ? {1'b1, {(W-1){1'b0}}} : '0;

    for (genvar k = 0; k < CH; k++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                codes[k*W +: W] <= RST_CODE;
            else if (wr_en[k])
                codes[k*W +: W] <= wdata;
        end
    end
endmodule

// File: rtl/quad_dac_out_rank.sv
module quad_dac_out_rank #(
    parameter int W         = 12,
    parameter int CH        = 4,
    parameter bit RESET_MID = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_n,
    input  logic [CH*W-1:0] stage,
    output logic [CH*W-1:0] codes
);
    localparam logic [W-1:0] RST_CODE = RESET_MID ? {1'b1, {(W-1){1'b0}}} : '0;

    for (genvar k = 0; k < CH; k++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                codes[k*W +: W] <= RST_CODE;
            else if (!load_n)
                codes[k*W +: W] <= stage[k*W +: W];
        end
    end
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
    import quad_dac_pkg::*;
#(
    parameter int W         = 12,
    parameter int CH        = 4,
    parameter bit RESET_MID = 1'b1,
    localparam int AW       = $clog2(CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rw,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata,
    output logic            rd_oe,
    input  logic            load_n,
    output logic [CH*W-1:0] dac_codes
);
    bus_op_e         op;
    logic [CH-1:0]   wr_en;
    logic [CH*W-1:0] stage_codes;

    quad_dac_bus_decode #(.CH(CH)) u_dec (
        .cs_n  (cs_n),
        .rw    (rw),
        .addr  (addr),
        .op    (op),
        .wr_en (wr_en),
        .rd_oe (rd_oe)
    );

    quad_dac_stage_rank #(.W(W), .CH(CH), .RESET_MID(RESET_MID)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .codes (stage_codes)
    );

    quad_dac_out_rank #(.W(W), .CH(CH), .RESET_MID(RESET_MID)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .stage  (stage_codes),
        .codes  (dac_codes)
    );

    // readback drives the staging word only during a read operation
    always_comb begin
        rdata = '0;
        if (op == OP_READ)
            rdata = stage_codes[addr*W +: W];
    end
endmodule

// File: rtl/quad_dac_front_chk.sv
module quad_dac_front_chk #(
    parameter int W         = 12,
    parameter int CH        = 4,
    parameter bit RESET_MID = 1'b1,
    localparam int AW       = $clog2(CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            rw,
    input logic [AW-1:0]   addr,
    input logic [W-1:0]    wdata,
    input logic [W-1:0]    rdata,
    input logic            rd_oe,
    input logic            load_n,
    input logic [CH*W-1:0] dac_codes,
    input logic [CH*W-1:0] stage_codes
);
    localparam logic [W-1:0] RST_CODE = RESET_MID ? {1'b1, {(W-1){1'b0}}} : '0;

    p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rw) |=> stage_codes[$past(addr)*W +: W] == $past(wdata));

    for (genvar k = 0; k < CH; k++) begin : g_ch
        p_no_write_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cs_n || rw || addr != AW'(k)) |=> $stable(stage_codes[k*W +: W]));
    end

    p_oe_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw) |-> rd_oe);

    p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !rd_oe);

    p_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> rdata == stage_codes[addr*W +: W]);

    p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> dac_codes == $past(stage_codes));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(dac_codes));

    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_code_r8: assert (dac_codes == {CH{RST_CODE}} && stage_codes == {CH{RST_CODE}});
        end
    end
endmodule

bind quad_dac_front quad_dac_front_chk #(.W(W), .CH(CH), .RESET_MID(RESET_MID)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rw          (rw),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rd_oe       (rd_oe),
    .load_n      (load_n),
    .dac_codes   (dac_codes),
    .stage_codes (stage_codes)
);

// File: tb/quad_dac_front_test.sv
module quad_dac_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rw = 1'b0;
    logic [1:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic        load_n = 1'b1;
    logic [11:0] rdata, rdata0;
    logic        rd_oe, rd_oe0;
    logic [47:0] dac_codes, dac_codes0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [11:0] st_m [4];
    logic [11:0] dac_m [4];

    always #4 clk = ~clk;

    quad_dac_front #(.RESET_MID(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe), .load_n(load_n),
        .dac_codes(dac_codes)
    );

    quad_dac_front #(.RESET_MID(1'b0)) uut_zero (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata0), .rd_oe(rd_oe0), .load_n(load_n),
        .dac_codes(dac_codes0)
    );

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ch_of(input logic [47:0] v, input int k);
        return v[k*12 +: 12];
    endfunction

    task automatic model_reset(input logic [11:0] code);
        for (int k = 0; k < 4; k++) begin
            st_m[k] = code;
            dac_m[k] = code;
        end
    endtask

    task automatic check_dacs(input string tag);
        for (int k = 0; k < 4; k++)
            chk(ch_of(dac_codes, k) === dac_m[k], tag, 48'(ch_of(dac_codes, k)), 48'(dac_m[k]));
    endtask

    // called at a falling edge: drive, check read path, clock, update model, check outputs
    task automatic cycle(input logic c, input logic r, input logic [1:0] a,
                         input logic [11:0] d, input logic l, input string tag);
        cs_n = c; rw = r; addr = a; wdata = d; load_n = l;
        #1;
        chk(rd_oe === (!c && r), "R4 oe", 48'(rd_oe), 48'(!c && r));
        if (!c && r)
            chk(rdata === st_m[a], "R4 readback", 48'(rdata), 48'(st_m[a]));
        @(posedge clk);
        if (!l)
            for (int k = 0; k < 4; k++) dac_m[k] = st_m[k];
        if (!c && !r)
            st_m[a] = d;
        @(negedge clk);
        check_dacs(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        void'($urandom(20240611));
        #2 rst_n = 1'b0;
        #1;
        chk(dac_codes === {4{12'h800}}, "R8 mid reset", dac_codes, {4{12'h800}});
        chk(dac_codes0 === 48'h0, "R8 zero reset", dac_codes0, 48'h0);
        model_reset(12'h800);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R8 readback after reset
        for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, 2'(k), 12'h0, 1'b1, "R8 R9 read after reset");
        // R1 address map: distinct codes per channel, then load
        cycle(1'b0, 1'b0, 2'd0, 12'h1A1, 1'b1, "R1 R5 hold");
        cycle(1'b0, 1'b0, 2'd1, 12'h2B2, 1'b1, "R1 R5 hold");
        cycle(1'b0, 1'b0, 2'd2, 12'h3C3, 1'b1, "R1 R5 hold");
        cycle(1'b0, 1'b0, 2'd3, 12'h4D4, 1'b1, "R1 R5 hold");
        // R7 one load cycle updates all four together
        cycle(1'b1, 1'b0, 2'd0, 12'h0, 1'b0, "R7 simultaneous");
        chk(dac_codes === {12'h4D4, 12'h3C3, 12'h2B2, 12'h1A1}, "R1 R7 packed",
            dac_codes, {12'h4D4, 12'h3C3, 12'h2B2, 12'h1A1});
        // R3 chip select high: write attempt ignored, seen by readback
        cycle(1'b1, 1'b0, 2'd2, 12'hFFF, 1'b1, "R3 deselected");
        cycle(1'b0, 1'b1, 2'd2, 12'h0, 1'b1, "R3 R4 readback");
        // R6 write with load low in the same cycle
        cycle(1'b0, 1'b0, 2'd0, 12'h5E5, 1'b0, "R6 first edge");
        chk(ch_of(dac_codes, 0) === 12'h1A1, "R6 old value", 48'(ch_of(dac_codes, 0)), 48'h1A1);
        cycle(1'b1, 1'b0, 2'd0, 12'h0, 1'b0, "R6 second edge");
        chk(ch_of(dac_codes, 0) === 12'h5E5, "R6 new value", 48'(ch_of(dac_codes, 0)), 48'h5E5);
        // R4 readback returns stage not converter rank
        cycle(1'b0, 1'b0, 2'd3, 12'h777, 1'b1, "R4 stage");
        cycle(1'b0, 1'b1, 2'd3, 12'h0, 1'b1, "R4 stage not dac");
        chk(ch_of(dac_codes, 3) === 12'h4D4, "R4 dac unchanged", 48'(ch_of(dac_codes, 3)), 48'h4D4);
        // random mix: R2 R5 R9
        for (int i = 0; i < 400; i++) begin
            v = 12'($urandom);
            cycle(1'($urandom % 4 == 0), 1'($urandom), 2'($urandom), v,
                  1'($urandom % 3 == 0), "R2 R5 R9 random");
        end
        // R8 asynchronous reset in mid cycle
        #1 rst_n = 1'b0;
        #1;
        chk(dac_codes === {4{12'h800}}, "R8 async mid", dac_codes, {4{12'h800}});
        chk(dac_codes0 === 48'h0, "R8 async zero", dac_codes0, 48'h0);
        model_reset(12'h800);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cycle(1'b0, 1'b1, 2'd1, 12'h0, 1'b1, "R8 readback");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule